// File: doc/BRIEF.md
# Host Mailbox Port

This block is a shared mailbox between an external host bus and a processor core. It holds six 16-bit data registers that both sides can reach, plus two status registers. The host side is asynchronous to the core clock. Every host strobe and bus value passes through a two-flop synchroniser before it changes any state.

The block records two things for each data register: whether the host has written it and the core has not yet consumed the value, and whether the host has read it since the core last wrote it. A completed host write or host read raises a one-cycle core interrupt pulse. The pulse fires only when both the per-register mask bit and the matching global enable are set. A soft-reset bit can be set from either side; it clears the flags and the byte sequencing.

Three static configuration pins select the host bus style:
- 8-bit or 16-bit transfers.
- Separate read and write strobes, or one read/write line qualified by a data strobe.
- A separate 3-bit address bus, or an address multiplexed onto the data bus and captured while an address-latch-enable is high.

Top module: `mbx_host_port`

## Requirements
- R1: After reset, data registers 0..5 read 0 from the core port, status registers 6 and 7 read 0, and irq_hwr, irq_hrd and sreset_pulse are low.
- R2: A completed 16-bit host write to address i (0..5) stores the word in register i and sets bit i of status register 6 (host-write flags in bits 5:0).
- R3: While a host read of address i (0..5) is active, h_data_out carries register i and h_data_oe is high. Completion of the read sets bit 8+i of status register 6 (host-read flags in bits 13:8).
- R4: A core read (core_rd) of register i clears its host-write flag. A core write (core_wr) stores core_wdata into register i and clears its host-read flag. Core reads of status registers change nothing.
- R5: irq_hwr pulses for one cycle per completed host write to register i only when mask_wr[i] and glb_wr_en are both 1.
- R6: irq_hrd pulses for one cycle per completed host read of register i only when mask_rd[i] and glb_rd_en are both 1.
- R7: With cfg_byte_mode=1, a host write is two accesses carrying the low byte and then the high byte on h_data_in[7:0]. The register, its flag and the interrupt change only after the high byte. A low byte alone leaves them unchanged.
- R8: With cfg_byte_mode=1, a host read is two accesses. The first returns the low byte on h_data_out[7:0]. The second returns the high byte as it stood when the first access completed. The flag and interrupt follow the second access.
- R9: With cfg_single_strobe=1, h_ds_n low marks an access: a read when h_rw=1 and a write when h_rw=0. h_rd_n and h_wr_n are ignored.
- R10: With cfg_mux_bus=1, the register address is taken from h_data_in[2:0] while h_ale is high, and h_addr is ignored.
- R11: Writing 1 to bit 0 of address 7, from the host or the core, clears all host-write and host-read flags and both byte sequences. It also gives one sreset_pulse, after which the bit reads 0. Data registers keep their contents.
- R12: Host writes to address 6, and host writes to address 7 with bit 0 clear, change no register, flag or pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_byte_mode | input | 1 | 1: 8-bit host transfers, low byte first |
| cfg_single_strobe | input | 1 | 1: read/write line plus data strobe |
| cfg_mux_bus | input | 1 | 1: address multiplexed on data bus with latch enable |
| h_rd_n | input | 1 | Host read strobe, active low (separate-strobe mode) |
| h_wr_n | input | 1 | Host write strobe, active low (separate-strobe mode) |
| h_ds_n | input | 1 | Host data strobe, active low (single-strobe mode) |
| h_rw | input | 1 | Host direction, 1 read / 0 write (single-strobe mode) |
| h_ale | input | 1 | Host address latch enable (multiplexed mode) |
| h_addr | input | 3 | Host register address (separate-bus mode) |
| h_data_in | input | 16 | Host write data, or address in multiplexed mode |
| h_data_out | output | 16 | Host read data |
| h_data_oe | output | 1 | High while a host read strobe is active |
| core_addr | input | 3 | Core register address |
| core_wr | input | 1 | Core write enable |
| core_rd | input | 1 | Core read enable (consumes host-write flag) |
| core_wdata | input | 16 | Core write data |
| core_rdata | output | 16 | Core read data |
| mask_wr | input | 6 | Per-register host-write interrupt mask |
| mask_rd | input | 6 | Per-register host-read interrupt mask |
| glb_wr_en | input | 1 | Global enable for host-write interrupts |
| glb_rd_en | input | 1 | Global enable for host-read interrupts |
| irq_hwr | output | 1 | Host-write interrupt pulse |
| irq_hrd | output | 1 | Host-read interrupt pulse |
| sreset_pulse | output | 1 | One-cycle soft-reset pulse |

## Verification
The bench targets a lone low byte in 8-bit mode. A design that commits on the first byte would change the register early and raise a spurious flag and interrupt. It also checks the high-byte snapshot on reads: a design that re-reads the live register would return a byte the core wrote between the two accesses.

A soft reset issued with a low byte pending must restart the byte sequence. Otherwise the next full write lands with its bytes swapped. Writes to status address 6, and to address 7 with bit 0 clear, must leave the flags untouched. Random traffic across all eight bus-style combinations, with masks that change between operations, exposes any interrupt that ignores either mask level, and any flag that is set or cleared by the wrong side.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NDATA = 6;
  localparam int AW    = $clog2(NDATA + 2);
  localparam int DW    = 16;
  localparam int BW    = DW / 2;
  localparam int CTL_W = 5;
  localparam logic [AW-1:0] ADDR_FLAGS = AW'(NDATA);
  localparam logic [AW-1:0] ADDR_CTRL  = AW'(NDATA + 1);

  typedef logic [DW-1:0] word_t;

  // Register file read view shared by host and core ports.
  function automatic word_t mbx_read(input logic [NDATA-1:0][DW-1:0] d,
                                     input logic [NDATA-1:0] wf,
                                     input logic [NDATA-1:0] rf,
                                     input logic srst,
                                     input logic [AW-1:0] a);
    word_t w;
    w = '0;
    if (a == ADDR_FLAGS) begin
      w = {{(BW-NDATA){1'b0}}, rf, {(BW-NDATA){1'b0}}, wf};
    end else if (a == ADDR_CTRL) begin
      w = {{(DW-1){1'b0}}, srst};
    end else begin
      for (int i = 0; i < NDATA; i++) begin
        if (a == AW'(i)) w = d[i];
      end
    end
    return w;
  endfunction
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_host_fsm.sv
module mbx_host_fsm
  import mbx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_byte,
  input  logic             cfg_single,
  input  logic             cfg_mux,
  input  logic [CTL_W-1:0] ctl_s,      // {ale, rw, ds_n, wr_n, rd_n}
  input  logic [AW-1:0]    addr_s,
  input  word_t            data_s,
  input  logic             sclr,
  input  word_t            cap_word,
  output logic [AW-1:0]    cap_addr,
  output logic [AW-1:0]    ale_addr,
  output logic             rd_phase,
  output logic [BW-1:0]    rd_hi,
  output logic             hw_commit,
  output logic [AW-1:0]    hw_addr,
  output word_t            hw_data,
  output logic             hr_event,
  output logic [AW-1:0]    hr_addr
);
  logic s_rd_n, s_wr_n, s_ds_n, s_rw, s_ale;
  assign {s_ale, s_rw, s_ds_n, s_wr_n, s_rd_n} = ctl_s;

  logic rd_act, wr_act, rd_act_q, wr_act_q, rd_done, wr_done;
  assign rd_act  = cfg_single ? (!s_ds_n &&  s_rw) : !s_rd_n;
  assign wr_act  = cfg_single ? (!s_ds_n && !s_rw) : !s_wr_n;
  assign rd_done = rd_act_q && !rd_act;
  assign wr_done = wr_act_q && !wr_act;

  logic [AW-1:0] ale_addr_q, cap_addr_q, hw_addr_q, hr_addr_q;
  logic [AW-1:0] hw_addr_n, hr_addr_n;
  word_t         cap_data_q, hw_data_q, hw_data_n;
  logic [BW-1:0] wlo_q, wlo_n, rhi_q, rhi_n;
  logic          wr_phase_q, wr_phase_n, rd_phase_q, rd_phase_n;
  logic          hw_commit_q, hw_commit_n, hr_event_q, hr_event_n;
  logic          ale_en, cap_en, dat_en;

  assign ale_en = s_ale;
  assign cap_en = rd_act || wr_act;
  assign dat_en = wr_act;

  // Next-state logic for byte sequencing and completion events.
  always_comb begin
    wlo_n       = wlo_q;
    rhi_n       = rhi_q;
    wr_phase_n  = wr_phase_q;
    rd_phase_n  = rd_phase_q;
    hw_commit_n = 1'b0;
    hw_addr_n   = hw_addr_q;
    hw_data_n   = hw_data_q;
    hr_event_n  = 1'b0;
    hr_addr_n   = hr_addr_q;
    if (wr_done) begin
      if (cfg_byte && !wr_phase_q) begin
        wlo_n      = cap_data_q[BW-1:0];
        wr_phase_n = 1'b1;
      end else begin
        hw_commit_n = 1'b1;
        hw_addr_n   = cap_addr_q;
        hw_data_n   = cfg_byte ? {cap_data_q[BW-1:0], wlo_q} : cap_data_q;
        wr_phase_n  = 1'b0;
      end
    end
    if (rd_done) begin
      if (cfg_byte && !rd_phase_q) begin
        rhi_n      = cap_word[DW-1:BW];
        rd_phase_n = 1'b1;
      end else begin
        hr_event_n = 1'b1;
        hr_addr_n  = cap_addr_q;
        rd_phase_n = 1'b0;
      end
    end
    if (sclr) begin
      wr_phase_n = 1'b0;
      rd_phase_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act_q    <= 1'b0;
      wr_act_q    <= 1'b0;
      ale_addr_q  <= '0;
      cap_addr_q  <= '0;
      cap_data_q  <= '0;
      wlo_q       <= '0;
      rhi_q       <= '0;
      wr_phase_q  <= 1'b0;
      rd_phase_q  <= 1'b0;
      hw_commit_q <= 1'b0;
      hw_addr_q   <= '0;
      hw_data_q   <= '0;
      hr_event_q  <= 1'b0;
      hr_addr_q   <= '0;
    end else begin
      rd_act_q    <= rd_act;
      wr_act_q    <= wr_act;
      if (ale_en) ale_addr_q <= data_s[AW-1:0];
      if (cap_en) cap_addr_q <= cfg_mux ? ale_addr_q : addr_s;
      if (dat_en) cap_data_q <= data_s;
      wlo_q       <= wlo_n;
      rhi_q       <= rhi_n;
      wr_phase_q  <= wr_phase_n;
      rd_phase_q  <= rd_phase_n;
      hw_commit_q <= hw_commit_n;
      hw_addr_q   <= hw_addr_n;
      hw_data_q   <= hw_data_n;
      hr_event_q  <= hr_event_n;
      hr_addr_q   <= hr_addr_n;
    end
  end

  assign cap_addr  = cap_addr_q;
  assign ale_addr  = ale_addr_q;
  assign rd_phase  = rd_phase_q;
  assign rd_hi     = rhi_q;
  assign hw_commit = hw_commit_q;
  assign hw_addr   = hw_addr_q;
  assign hw_data   = hw_data_q;
  assign hr_event  = hr_event_q;
  assign hr_addr   = hr_addr_q;

  // In byte mode a commit must follow a completed low byte.
  AST_BYTE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_commit_q && cfg_byte && $past(cfg_byte)) |-> $past(wr_phase_q)); // R7
  AST_RD_BYTE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_event_q && cfg_byte && $past(cfg_byte)) |-> $past(rd_phase_q)); // R8
endmodule

// File: rtl/mbx_regs.sv
module mbx_regs
  import mbx_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hw_commit,
  input  logic [AW-1:0]            hw_addr,
  input  word_t                    hw_data,
  input  logic                     hr_event,
  input  logic [AW-1:0]            hr_addr,
  input  logic                     core_wr,
  input  logic                     core_rd,
  input  logic [AW-1:0]            core_addr,
  input  word_t                    core_wdata,
  input  logic [NDATA-1:0]         mask_wr,
  input  logic [NDATA-1:0]         mask_rd,
  input  logic                     glb_wr_en,
  input  logic                     glb_rd_en,
  output logic [NDATA-1:0][DW-1:0] data,
  output logic [NDATA-1:0]         wflag,
  output logic [NDATA-1:0]         rflag,
  output logic                     srst,
  output logic                     irq_hwr,
  output logic                     irq_hrd
);
  logic [NDATA-1:0] hw_hit, hr_hit, cw_hit, cr_hit;
  logic [NDATA-1:0][DW-1:0] data_q;
  logic [NDATA-1:0] wf_q, wf_n, rf_q, rf_n;
  logic srst_q, srst_n, irq_w_q, irq_w_n, irq_r_q, irq_r_n;

  for (genvar i = 0; i < NDATA; i++) begin : g_reg
    assign hw_hit[i] = hw_commit && (hw_addr == AW'(i));
    assign hr_hit[i] = hr_event  && (hr_addr == AW'(i));
    assign cw_hit[i] = core_wr   && (core_addr == AW'(i));
    assign cr_hit[i] = core_rd   && (core_addr == AW'(i));

    logic  den;
    word_t dnx;
    assign den = hw_hit[i] || cw_hit[i];
    assign dnx = hw_hit[i] ? hw_data : core_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   data_q[i] <= '0;
      else if (den) data_q[i] <= dnx;
    end
  end

  always_comb begin
    wf_n = srst_q ? '0 : (wf_q & ~cr_hit);
    wf_n = wf_n | hw_hit;
    rf_n = srst_q ? '0 : (rf_q & ~cw_hit);
    rf_n = rf_n | hr_hit;
    srst_n = (hw_commit && hw_addr == ADDR_CTRL && hw_data[0]) ||
             (core_wr && core_addr == ADDR_CTRL && core_wdata[0]);
    irq_w_n = glb_wr_en && |(hw_hit & mask_wr);
    irq_r_n = glb_rd_en && |(hr_hit & mask_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wf_q    <= '0;
      rf_q    <= '0;
      srst_q  <= 1'b0;
      irq_w_q <= 1'b0;
      irq_r_q <= 1'b0;
    end else begin
      wf_q    <= wf_n;
      rf_q    <= rf_n;
      srst_q  <= srst_n;
      irq_w_q <= irq_w_n;
      irq_r_q <= irq_r_n;
    end
  end

  assign data    = data_q;
  assign wflag   = wf_q;
  assign rflag   = rf_q;
  assign srst    = srst_q;
  assign irq_hwr = irq_w_q;
  assign irq_hrd = irq_r_q;

  AST_WF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_commit && hw_addr < ADDR_FLAGS) |=> wf_q[$past(hw_addr)]); // R2
  AST_RF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_event && hr_addr < ADDR_FLAGS) |=> rf_q[$past(hr_addr)]); // R3
  AST_WF_CONSUME: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rd && core_addr < ADDR_FLAGS && !(hw_commit && hw_addr == core_addr))
      |=> !wf_q[$past(core_addr)]); // R4
  AST_IRQ_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_w_q |-> ($past(glb_wr_en) && $past(hw_commit))); // R5
  AST_IRQ_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_r_q |-> ($past(glb_rd_en) && $past(hr_event))); // R6
  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_q && !hw_commit && !hr_event) |=> (wf_q == '0 && rf_q == '0)); // R11
endmodule

// File: rtl/mbx_host_port.sv
module mbx_host_port
  import mbx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_byte_mode,
  input  logic              cfg_single_strobe,
  input  logic              cfg_mux_bus,
  input  logic              h_rd_n,
  input  logic              h_wr_n,
  input  logic              h_ds_n,
  input  logic              h_rw,
  input  logic              h_ale,
  input  logic [AW-1:0]     h_addr,
  input  logic [DW-1:0]     h_data_in,
  output logic [DW-1:0]     h_data_out,
  output logic              h_data_oe,
  input  logic [AW-1:0]     core_addr,
  input  logic              core_wr,
  input  logic              core_rd,
  input  logic [DW-1:0]     core_wdata,
  output logic [DW-1:0]     core_rdata,
  input  logic [NDATA-1:0]  mask_wr,
  input  logic [NDATA-1:0]  mask_rd,
  input  logic              glb_wr_en,
  input  logic              glb_rd_en,
  output logic              irq_hwr,
  output logic              irq_hrd,
  output logic              sreset_pulse
);
  logic [CTL_W-1:0] ctl_s;
  logic [AW-1:0]    addr_s;
  word_t            data_s;

  mbx_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_W'(5'b00111))) u_sync_ctl (
    .clk(clk), .rst_n(rst_n),
    .d({h_ale, h_rw, h_ds_n, h_wr_n, h_rd_n}), .q(ctl_s));
  mbx_sync #(.W(AW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_addr (
    .clk(clk), .rst_n(rst_n), .d(h_addr), .q(addr_s));
  mbx_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_data (
    .clk(clk), .rst_n(rst_n), .d(h_data_in), .q(data_s));

  logic [AW-1:0]            cap_addr, ale_addr, hw_addr, hr_addr, out_addr;
  logic                     rd_phase, hw_commit, hr_event, srst;
  logic [BW-1:0]            rd_hi;
  word_t                    hw_data, cap_word, out_word;
  logic [NDATA-1:0][DW-1:0] data;
  logic [NDATA-1:0]         wflag, rflag;

  mbx_host_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cfg_byte(cfg_byte_mode), .cfg_single(cfg_single_strobe), .cfg_mux(cfg_mux_bus),
    .ctl_s(ctl_s), .addr_s(addr_s), .data_s(data_s),
    .sclr(srst), .cap_word(cap_word),
    .cap_addr(cap_addr), .ale_addr(ale_addr), .rd_phase(rd_phase), .rd_hi(rd_hi),
    .hw_commit(hw_commit), .hw_addr(hw_addr), .hw_data(hw_data),
    .hr_event(hr_event), .hr_addr(hr_addr));

  mbx_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .hw_commit(hw_commit), .hw_addr(hw_addr), .hw_data(hw_data),
    .hr_event(hr_event), .hr_addr(hr_addr),
    .core_wr(core_wr), .core_rd(core_rd), .core_addr(core_addr), .core_wdata(core_wdata),
    .mask_wr(mask_wr), .mask_rd(mask_rd), .glb_wr_en(glb_wr_en), .glb_rd_en(glb_rd_en),
    .data(data), .wflag(wflag), .rflag(rflag), .srst(srst),
    .irq_hwr(irq_hwr), .irq_hrd(irq_hrd));

  assign out_addr   = cfg_mux_bus ? ale_addr : h_addr;
  assign out_word   = mbx_read(data, wflag, rflag, srst, out_addr);
  assign cap_word   = mbx_read(data, wflag, rflag, srst, cap_addr);
  assign core_rdata = mbx_read(data, wflag, rflag, srst, core_addr);

  always_comb begin
    if (!cfg_byte_mode)  h_data_out = out_word;
    else if (rd_phase)   h_data_out = {{BW{1'b0}}, rd_hi};
    else                 h_data_out = {{BW{1'b0}}, out_word[BW-1:0]};
  end

  assign h_data_oe    = cfg_single_strobe ? (!h_ds_n && h_rw) : !h_rd_n;
  assign sreset_pulse = srst;

  AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sreset_pulse && !core_wr && !hw_commit) |=> !sreset_pulse); // R11
endmodule

// File: tb/mbx_host_port_tb_top.sv
module mbx_host_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cfg_byte_mode = 0, cfg_single_strobe = 0, cfg_mux_bus = 0;
  logic        h_rd_n = 1, h_wr_n = 1, h_ds_n = 1, h_rw = 0, h_ale = 0;
  logic [2:0]  h_addr = 0;
  logic [15:0] h_data_in = 0;
  logic [15:0] h_data_out;
  logic        h_data_oe;
  logic [2:0]  core_addr = 0;
  logic        core_wr = 0, core_rd = 0;
  logic [15:0] core_wdata = 0;
  logic [15:0] core_rdata;
  logic [5:0]  mask_wr = 0, mask_rd = 0;
  logic        glb_wr_en = 0, glb_rd_en = 0;
  logic        irq_hwr, irq_hrd, sreset_pulse;

  mbx_host_port dut_i (.*);

  int nchk = 0, nerr = 0;
  int cnt_wr = 0, cnt_rd = 0, cnt_sr = 0;
  int exp_wr = 0, exp_rd = 0, exp_sr = 0;
  logic [15:0] m_reg [6];
  logic [5:0]  m_wf = 0, m_rf = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (irq_hwr) cnt_wr++;
      if (irq_hrd) cnt_rd++;
      if (sreset_pulse) cnt_sr++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string mode_tag(input bit rd);
    if (cfg_mux_bus) return "R10";
    if (cfg_single_strobe) return "R9";
    if (cfg_byte_mode) return rd ? "R8" : "R7";
    return rd ? "R3" : "R2";
  endfunction

  // One strobe cycle on the host bus in the current bus style.
  task automatic host_access(input bit is_wr, input logic [2:0] a, input logic [15:0] d,
                             output logic [15:0] rd, output logic oe);
    @(negedge clk);
    if (cfg_mux_bus) begin
      h_data_in = {13'h0, a};
      h_addr = ~a;
      h_ale = 1;
      repeat (4) @(negedge clk);
      h_ale = 0;
      repeat (3) @(negedge clk);
    end else begin
      h_addr = a;
    end
    if (is_wr) h_data_in = d;
    if (cfg_single_strobe) begin
      h_rw = !is_wr;
      h_rd_n = 0; h_wr_n = 0;   // ignored in this mode
      @(negedge clk);
      h_ds_n = 0;
    end else begin
      if (is_wr) h_wr_n = 0; else h_rd_n = 0;
    end
    repeat (4) @(negedge clk);
    rd = h_data_out;
    oe = h_data_oe;
    h_rd_n = 1; h_wr_n = 1; h_ds_n = 1;
    repeat (7) @(negedge clk);
  endtask

  task automatic host_write(input logic [2:0] a, input logic [15:0] d);
    logic [15:0] x; logic oe;
    if (cfg_byte_mode) begin
      host_access(1, a, {8'h00, d[7:0]}, x, oe);
      host_access(1, a, {8'h00, d[15:8]}, x, oe);
    end else begin
      host_access(1, a, d, x, oe);
    end
    if (a < 6) begin
      m_reg[a] = d; m_wf[a] = 1;
      if (mask_wr[a] && glb_wr_en) exp_wr++;
    end else if (a == 7 && d[0]) begin
      m_wf = 0; m_rf = 0; exp_sr++;
    end
  endtask

  task automatic host_read(input logic [2:0] a);
    logic [15:0] x; logic oe;
    string t;
    t = mode_tag(1);
    if (cfg_byte_mode) begin
      host_access(0, a, 16'h0, x, oe);
      check(x == {8'h0, m_reg[a][7:0]}, {t, " low byte read"}, x, {8'h0, m_reg[a][7:0]});
      host_access(0, a, 16'h0, x, oe);
      check(x == {8'h0, m_reg[a][15:8]}, {t, " high byte read"}, x, {8'h0, m_reg[a][15:8]});
    end else begin
      host_access(0, a, 16'h0, x, oe);
      check(x == m_reg[a] && oe, {t, " host read data R3"}, x, m_reg[a]);
    end
    m_rf[a] = 1;
    if (mask_rd[a] && glb_rd_en) exp_rd++;
  endtask

  task automatic core_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    core_addr = a; core_wdata = d; core_wr = 1;
    @(negedge clk);
    core_wr = 0;
    if (a < 6) begin m_reg[a] = d; m_rf[a] = 0; end
    else if (a == 7 && d[0]) begin m_wf = 0; m_rf = 0; exp_sr++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic core_read(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    core_addr = a; core_rd = 1;
    #1 v = core_rdata;
    @(negedge clk);
    core_rd = 0;
    if (a < 6) m_wf[a] = 0;
  endtask

  task automatic check_status(input string req);
    logic [15:0] v, e;
    e = {2'b0, m_rf, 2'b0, m_wf};
    core_read(3'd6, v);
    check(v == e, req, v, e);
    check(cnt_wr == exp_wr, "R5 write irq count", 16'(cnt_wr), 16'(exp_wr));
    check(cnt_rd == exp_rd, "R6 read irq count", 16'(cnt_rd), 16'(exp_rd));
    check(cnt_sr == exp_sr, "R11 soft reset pulses", 16'(cnt_sr), 16'(exp_sr));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, snap;
    logic [2:0] a;
    void'($urandom(32'd20240607));
    for (int i = 0; i < 6; i++) m_reg[i] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check(!irq_hwr && !irq_hrd && !sreset_pulse, "R1 outputs low", {13'h0, irq_hwr, irq_hrd, sreset_pulse}, 16'h0);
    for (int i = 0; i < 8; i++) begin
      core_read(3'(i), v);
      check(v == 16'h0, "R1 register after reset", v, 16'h0);
    end

    // R2/R5: masked write interrupts, both levels
    mask_wr = 6'b000100; glb_wr_en = 0;
    host_write(3'd2, 16'hBEEF);
    check_status("R5 global write enable off");
    glb_wr_en = 1;
    host_write(3'd3, 16'h1357);
    host_write(3'd2, 16'hCAFE);
    check_status("R2 write flags");
    core_read(3'd2, v);
    check(v == 16'hCAFE, "R4 core read data", v, 16'hCAFE);
    check_status("R4 core read clears write flag");

    // R12: writes to status registers ignored
    snap = {2'b0, m_rf, 2'b0, m_wf};
    begin logic [15:0] x; logic oe; host_access(1, 3'd6, 16'hFFFF, x, oe); end
    check_status("R12 host write to status 6 ignored");
    begin logic [15:0] x; logic oe; host_access(1, 3'd7, 16'hFFFE, x, oe); end
    check_status("R12 host write to 7 bit0 clear ignored");
    core_read(3'd6, v);
    check(v == snap, "R12 flags unchanged", v, snap);

    // R11: host-issued soft reset keeps data
    host_read(3'd3);
    host_write(3'd7, 16'h0001);
    check_status("R11 host soft reset clears flags");
    core_read(3'd3, v);
    check(v == 16'h1357, "R11 data kept", v, 16'h1357);

    // R7: lone low byte leaves state untouched, soft reset restarts sequence
    cfg_byte_mode = 1;
    core_write(3'd7, 16'h0001);
    core_write(3'd1, 16'h5555);
    begin logic [15:0] x; logic oe; host_access(1, 3'd1, 16'h00AA, x, oe); end
    core_read(3'd1, v);
    check(v == 16'h5555, "R7 low byte alone no commit", v, 16'h5555);
    check_status("R7 no flag after low byte");
    core_write(3'd7, 16'h0001);
    host_write(3'd1, 16'h1234);
    core_read(3'd1, v);
    check(v == 16'h1234, "R7 byte order after soft reset", v, 16'h1234);

    // R8: high byte is snapshotted at low byte completion
    core_write(3'd4, 16'h1111);
    begin
      logic [15:0] x; logic oe;
      host_access(0, 3'd4, 16'h0, x, oe);
      check(x == 16'h0011, "R8 low byte", x, 16'h0011);
      core_write(3'd4, 16'hABCD);
      host_access(0, 3'd4, 16'h0, x, oe);
      check(x == 16'h0011, "R8 high byte snapshot", x, 16'h0011);
      m_rf[4] = 1;
      if (mask_rd[4] && glb_rd_en) exp_rd++;
    end
    check_status("R8 read flag after high byte");

    // Random traffic over all bus styles
    for (int mode = 0; mode < 8; mode++) begin
      cfg_byte_mode = mode[0]; cfg_single_strobe = mode[1]; cfg_mux_bus = mode[2];
      core_write(3'd7, 16'h0001);
      for (int k = 0; k < 18; k++) begin
        a = 3'($urandom % 6);
        case ($urandom % 5)
          0: host_write(a, 16'($urandom));
          1: host_read(a);
          2: core_write(a, 16'($urandom));
          3: begin
               core_read(a, v);
               check(v == m_reg[a], "R4 core read value", v, m_reg[a]);
             end
          default: begin
               mask_wr = 6'($urandom); mask_rd = 6'($urandom);
               glb_wr_en = 1'($urandom); glb_rd_en = 1'($urandom);
             end
        endcase
        check_status(mode_tag(0));
      end
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule